// File: doc/BRIEF.md
# Stereo Echo FIR Filter and Feedback Mixer

This block takes one stereo echo word per sample tick, passes each channel through its own eight-stage delay line, and filters both channels with one shared set of eight signed 8-bit coefficients. The filtered echo goes two ways. Scaled by a signed echo volume, it is added to the main mix that arrives already scaled by master volume. Scaled by a signed feedback volume, it is added to the sum of the echo-enabled voices, and that result becomes the word written back into the echo buffer.

A sequencer waits for a tick. When it sees one, it shifts both delay lines, registers all outputs and raises `out_valid` for one cycle. Buffer addressing, memory timing and output muting are handled elsewhere. The write-back word carries 15 significant bits, left-aligned, with bit 0 always zero. `wb_en` tells the buffer side whether to store it. Filtering goes on whether or not write-back is allowed.

Top module: `echo_fir_mix`

Sequencer states: `ST_IDLE` (waiting for a tick) and `ST_HOLD` (outputs were just updated and `out_valid` is high). The transitions are IDLE to HOLD on a tick, HOLD to HOLD on a tick, and HOLD to IDLE when there is no tick.

## Requirements
- R1: While reset is active, all outputs are zero, `out_valid` and `wb_en` are low, and both delay lines hold zeros.
- R2: Each incoming 16-bit echo word is divided by two with an arithmetic shift right by one, keeping its sign. That value becomes the newest sample of its channel's delay line.
- R3: Each tap product is sample times coefficient, arithmetically shifted right by 6. Coefficient k sits at bits [8k+7:8k] of `fir_coef`. k=0 weights the sample from seven ticks ago and k=7 weights the sample arriving with the current tick.
- R4: The seven older tap products are summed with wraparound in signed 16-bit arithmetic.
- R5: The newest tap product is added to that wrapped sum, and the result is saturated to the signed 16-bit range.
- R6: Bit 0 of the filter result is forced to zero.
- R7: The main output equals the main input plus (filter result times the signed echo volume, arithmetically shifted right by 7, truncated to signed 16 bits). This sum is saturated to signed 16 bits.
- R8: The write-back word equals the echo-enabled voice sum plus (filter result times the signed feedback volume, shifted right by 7, truncated to 16 bits). This sum is saturated to signed 16 bits and then bit 0 is cleared.
- R9: When `echo_wr_dis` is high at a tick, `wb_en` is low for that result. Filtering and delay-line shifting continue exactly as when it is low.
- R10: The left channel's outputs depend only on left inputs and left history, and the right channel's only on right inputs and right history. Coefficients and feedback volume are shared.
- R11: Results appear and `out_valid` is high in the cycle after a tick. Without a tick, the outputs and the delay lines hold and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle sample strobe |
| echo_in_l | input | 16 | Left echo word read from the buffer |
| echo_in_r | input | 16 | Right echo word read from the buffer |
| fir_coef | input | 64 | Eight signed 8-bit coefficients, k at [8k+7:8k] |
| echo_vol_l | input | 8 | Signed left echo volume |
| echo_vol_r | input | 8 | Signed right echo volume |
| fb_vol | input | 8 | Signed feedback volume, both channels |
| main_in_l | input | 16 | Left main mix after master volume |
| main_in_r | input | 16 | Right main mix after master volume |
| eon_in_l | input | 16 | Left sum of echo-enabled voices |
| eon_in_r | input | 16 | Right sum of echo-enabled voices |
| echo_wr_dis | input | 1 | Suppresses write-back when high |
| mix_out_l | output | 16 | Left main output with echo added |
| mix_out_r | output | 16 | Right main output with echo added |
| wb_out_l | output | 16 | Left write-back word, bit 0 zero |
| wb_out_r | output | 16 | Right write-back word, bit 0 zero |
| wb_en | output | 1 | Write-back permitted for this result |
| out_valid | output | 1 | Outputs updated this cycle |

## Verification
A single impulse is sent through one channel, with an echo volume of -128 so that the main output shows the negated filter result. Its path through the coefficients shows the tap order and the one-bit input shift. Full-scale samples with full-scale coefficients push the seven-tap sum past 16 bits, so wraparound can be told apart from saturation, and they also drive the final add and the mix adds into both rails. Random words, coefficients and volumes run with one channel held at zero and with write-disable toggled, which separates the channels and shows that history keeps advancing while write-back is off. Idle gaps between ticks show the outputs holding.

// File: rtl/echo_fir_pkg.sv
package echo_fir_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } seq_state_t;

    localparam int ACC_W = 32;

    // truncate to signed 16 bits (wraparound)
    function automatic logic signed [15:0] wrap16(input logic signed [ACC_W-1:0] x);
        return x[15:0];
    endfunction

    // saturate to signed 16 bits
    function automatic logic signed [15:0] sat16(input logic signed [ACC_W-1:0] x);
        if (x > 32'sd32767)
            return 16'sh7FFF;
        else if (x < -32'sd32768)
            return 16'sh8000;
        else
            return x[15:0];
    endfunction

endpackage

// File: rtl/echo_hist_line.sv
module echo_hist_line #(
    parameter int DATA_W = 16,
    parameter int TAPS   = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick,
    input  logic [DATA_W-1:0]             din,
    output logic [DATA_W-1:0]             newest,
    output logic [(TAPS-1)*DATA_W-1:0]    hist_flat
);
    localparam int OLD = TAPS - 1;

    logic [DATA_W-1:0] hist [OLD];

    // arithmetic halving: 15-bit sample held sign-extended in DATA_W bits
    assign newest = DATA_W'($signed(din) >>> 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < OLD; i++) hist[i] <= '0;
        end else if (tick) begin
            for (int i = 0; i < OLD - 1; i++) hist[i] <= hist[i+1];
            hist[OLD-1] <= newest;
        end
    end

    generate
        for (genvar g = 0; g < OLD; g++) begin : g_flat
            assign hist_flat[g*DATA_W +: DATA_W] = hist[g];
        end
    endgenerate
endmodule

// File: rtl/echo_fir_taps.sv
module echo_fir_taps
    import echo_fir_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int COEF_W    = 8,
    parameter int TAPS      = 8,
    parameter int TAP_SHIFT = 6
) (
    input  logic [(TAPS-1)*DATA_W-1:0] hist_flat,
    input  logic [DATA_W-1:0]          newest,
    input  logic [TAPS*COEF_W-1:0]     coef_flat,
    output logic [15:0]                fir_out
);
    localparam int OLD = TAPS - 1;

    logic signed [ACC_W-1:0] prod [TAPS];

    generate
        for (genvar g = 0; g < TAPS; g++) begin : g_tap
            logic signed [ACC_W-1:0] s_ext;
            logic signed [ACC_W-1:0] c_ext;
            if (g < OLD) begin : g_old
                assign s_ext = ACC_W'($signed(hist_flat[g*DATA_W +: DATA_W]));
            end else begin : g_new
                assign s_ext = ACC_W'($signed(newest));
            end
            assign c_ext   = ACC_W'($signed(coef_flat[g*COEF_W +: COEF_W]));
            assign prod[g] = (s_ext * c_ext) >>> TAP_SHIFT;
        end
    endgenerate

    logic signed [15:0]      acc_wrap;
    logic signed [ACC_W-1:0] total;
    logic signed [15:0]      sat_res;

    always_comb begin
        acc_wrap = '0;
        for (int i = 0; i < OLD; i++)
            acc_wrap = wrap16(ACC_W'(acc_wrap) + prod[i]);
        total   = ACC_W'(acc_wrap) + prod[OLD];
        sat_res = sat16(total);
        fir_out = sat_res & ~16'd1;
    end
endmodule

// File: rtl/echo_vol_mix.sv
module echo_vol_mix
    import echo_fir_pkg::*;
#(
    parameter int VOL_W     = 8,
    parameter int VOL_SHIFT = 7
) (
    input  logic [15:0]      fir_in,
    input  logic [VOL_W-1:0] vol,
    input  logic [15:0]      base,
    output logic [15:0]      sum_out
);
    logic signed [ACC_W-1:0] f_ext;
    logic signed [ACC_W-1:0] v_ext;
    logic signed [15:0]      scaled;

    always_comb begin
        f_ext   = ACC_W'($signed(fir_in));
        v_ext   = ACC_W'($signed(vol));
        scaled  = wrap16((f_ext * v_ext) >>> VOL_SHIFT);
        sum_out = sat16(ACC_W'(scaled) + ACC_W'($signed(base)));
    end
endmodule

// File: rtl/echo_fir_mix.sv
module echo_fir_mix
    import echo_fir_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int COEF_W = 8,
    parameter int TAPS   = 8,
    parameter int VOL_W  = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick,
    input  logic [DATA_W-1:0]      echo_in_l,
    input  logic [DATA_W-1:0]      echo_in_r,
    input  logic [TAPS*COEF_W-1:0] fir_coef,
    input  logic [VOL_W-1:0]       echo_vol_l,
    input  logic [VOL_W-1:0]       echo_vol_r,
    input  logic [VOL_W-1:0]       fb_vol,
    input  logic [15:0]            main_in_l,
    input  logic [15:0]            main_in_r,
    input  logic [15:0]            eon_in_l,
    input  logic [15:0]            eon_in_r,
    input  logic                   echo_wr_dis,
    output logic [15:0]            mix_out_l,
    output logic [15:0]            mix_out_r,
    output logic [15:0]            wb_out_l,
    output logic [15:0]            wb_out_r,
    output logic                   wb_en,
    output logic                   out_valid
);
    localparam int NCH = 2;

    logic [DATA_W-1:0] ch_echo [NCH];
    logic [VOL_W-1:0]  ch_evol [NCH];
    logic [15:0]       ch_main [NCH];
    logic [15:0]       ch_eon  [NCH];
    logic [15:0]       ch_mix  [NCH];
    logic [15:0]       ch_wb   [NCH];
    logic [15:0]       mix_q   [NCH];
    logic [15:0]       wb_q    [NCH];

    assign ch_echo[0] = echo_in_l;  assign ch_echo[1] = echo_in_r;
    assign ch_evol[0] = echo_vol_l; assign ch_evol[1] = echo_vol_r;
    assign ch_main[0] = main_in_l;  assign ch_main[1] = main_in_r;
    assign ch_eon[0]  = eon_in_l;   assign ch_eon[1]  = eon_in_r;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            logic [DATA_W-1:0]          newest;
            logic [(TAPS-1)*DATA_W-1:0] hist_flat;
            logic [15:0]                fir;
            logic [15:0]                fb_sum;

            echo_hist_line #(.DATA_W(DATA_W), .TAPS(TAPS)) u_hist (
                .clk(clk), .rst_n(rst_n), .tick(tick),
                .din(ch_echo[c]), .newest(newest), .hist_flat(hist_flat)
            );

            echo_fir_taps #(.DATA_W(DATA_W), .COEF_W(COEF_W), .TAPS(TAPS)) u_taps (
                .hist_flat(hist_flat), .newest(newest),
                .coef_flat(fir_coef), .fir_out(fir)
            );

            echo_vol_mix #(.VOL_W(VOL_W)) u_main (
                .fir_in(fir), .vol(ch_evol[c]), .base(ch_main[c]), .sum_out(ch_mix[c])
            );

            echo_vol_mix #(.VOL_W(VOL_W)) u_fb (
                .fir_in(fir), .vol(fb_vol), .base(ch_eon[c]), .sum_out(fb_sum)
            );

            assign ch_wb[c] = fb_sum & ~16'd1;
        end
    endgenerate

    seq_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (tick)  state_d = ST_HOLD;
            ST_HOLD: if (!tick) state_d = ST_IDLE;
            default:            state_d = ST_IDLE;
        endcase
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                mix_q[i] <= '0;
                wb_q[i]  <= '0;
            end
            wb_en <= 1'b0;
        end else if (tick) begin
            for (int i = 0; i < NCH; i++) begin
                mix_q[i] <= ch_mix[i];
                wb_q[i]  <= ch_wb[i];
            end
            wb_en <= !echo_wr_dis;
        end else begin
            wb_en <= 1'b0;
        end
    end

    assign out_valid = (state_q == ST_HOLD);
    assign mix_out_l = mix_q[0];
    assign mix_out_r = mix_q[1];
    assign wb_out_l  = wb_q[0];
    assign wb_out_r  = wb_q[1];
endmodule

// File: rtl/echo_fir_mix_chk.sv
module echo_fir_mix_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic        echo_wr_dis,
    input logic [15:0] mix_out_l,
    input logic [15:0] mix_out_r,
    input logic [15:0] wb_out_l,
    input logic [15:0] wb_out_r,
    input logic        wb_en,
    input logic        out_valid
);
    // R1: outputs cleared while in reset
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_clear_r1: assert (mix_out_l == 16'd0 && mix_out_r == 16'd0 &&
                                      wb_out_l == 16'd0 && wb_out_r == 16'd0 &&
                                      !wb_en && !out_valid);
        end
    end

    p_valid_after_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> out_valid);

    p_quiet_without_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (!out_valid && $stable(mix_out_l) && $stable(mix_out_r) &&
                   $stable(wb_out_l) && $stable(wb_out_r)));

    p_wb_low_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (wb_out_l[0] == 1'b0 && wb_out_r[0] == 1'b0));

    p_wr_dis_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && echo_wr_dis) |=> !wb_en);

    p_wr_en_passes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !echo_wr_dis) |=> wb_en);

    p_wb_en_needs_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> out_valid);
endmodule

bind echo_fir_mix echo_fir_mix_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .echo_wr_dis(echo_wr_dis),
    .mix_out_l(mix_out_l), .mix_out_r(mix_out_r),
    .wb_out_l(wb_out_l), .wb_out_r(wb_out_r),
    .wb_en(wb_en), .out_valid(out_valid)
);

// File: tb/tb_echo_fir_mix.sv
`timescale 1ns/1ps
module tb_echo_fir_mix;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [15:0] echo_in_l = '0, echo_in_r = '0;
    logic [63:0] fir_coef = '0;
    logic [7:0]  echo_vol_l = '0, echo_vol_r = '0, fb_vol = '0;
    logic [15:0] main_in_l = '0, main_in_r = '0, eon_in_l = '0, eon_in_r = '0;
    logic        echo_wr_dis = 1'b0;
    logic [15:0] mix_out_l, mix_out_r, wb_out_l, wb_out_r;
    logic        wb_en, out_valid;

    int n_chk = 0;
    int n_bad = 0;
    int hl[7];
    int hr[7];

    always #2.5 clk = ~clk;

    echo_fir_mix dut (.*);

    function automatic int w16(int x);
        return ((x & 32'hFFFF) ^ 32'h8000) - 32'h8000;
    endfunction

    function automatic int c16(int x);
        return (x > 32767) ? 32767 : ((x < -32768) ? -32768 : x);
    endfunction

    function automatic int cf(int k);
        return int'($signed(fir_coef[k*8 +: 8]));
    endfunction

    // R3 R4 R5 R6 model
    function automatic int fir_model(int h[7], int nw);
        int s = 0;
        for (int k = 0; k < 7; k++) s = w16(s + ((h[k] * cf(k)) >>> 6));
        return c16(s + ((nw * cf(7)) >>> 6)) & ~1;
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_tick();
        int nl, nr, fl, fr, el, er, wl, wr;
        nl = int'($signed(echo_in_l)) >>> 1;   // R2
        nr = int'($signed(echo_in_r)) >>> 1;
        fl = fir_model(hl, nl);
        fr = fir_model(hr, nr);
        el = c16(int'($signed(main_in_l)) + w16((fl * int'($signed(echo_vol_l))) >>> 7));
        er = c16(int'($signed(main_in_r)) + w16((fr * int'($signed(echo_vol_r))) >>> 7));
        wl = c16(int'($signed(eon_in_l)) + w16((fl * int'($signed(fb_vol))) >>> 7)) & ~1;
        wr = c16(int'($signed(eon_in_r)) + w16((fr * int'($signed(fb_vol))) >>> 7)) & ~1;
        for (int k = 0; k < 6; k++) begin hl[k] = hl[k+1]; hr[k] = hr[k+1]; end
        hl[6] = nl; hr[6] = nr;
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        check("R11 valid", int'(out_valid), 1);
        check("R7 R10 mix_l", int'($signed(mix_out_l)), el);
        check("R7 R10 mix_r", int'($signed(mix_out_r)), er);
        check("R8 wb_l", int'($signed(wb_out_l)), wl);
        check("R8 wb_r", int'($signed(wb_out_r)), wr);
        check("R9 wb_en", int'(wb_en), echo_wr_dis ? 0 : 1);
    endtask

    task automatic zero_in();
        echo_in_l = '0; echo_in_r = '0; main_in_l = '0; main_in_r = '0;
        eon_in_l = '0; eon_in_r = '0;
    endtask

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int k = 0; k < 7; k++) begin hl[k] = 0; hr[k] = 0; end
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 mix_l", int'(mix_out_l), 0);
        check("R1 wb_r", int'(wb_out_r), 0);
        check("R1 valid", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R6: impulse with odd word, echo volume -128 shows -fir
        for (int k = 0; k < 8; k++) fir_coef[k*8 +: 8] = 8'(k * 9 + 5);
        echo_vol_l = 8'h80; echo_vol_r = 8'h80; fb_vol = 8'h40;
        echo_in_l = 16'h4001;
        do_tick();
        zero_in();
        for (int t = 0; t < 8; t++) do_tick();

        // R4 R5: full-scale positive and negative
        fir_coef = {8{8'h7F}};
        echo_vol_l = 8'h7F; echo_vol_r = 8'h81; fb_vol = 8'h7F;
        for (int t = 0; t < 9; t++) begin
            echo_in_l = 16'h7FFF; echo_in_r = 16'h8000;
            main_in_l = 16'h7000; main_in_r = 16'h9000;
            eon_in_l = 16'h7F00; eon_in_r = 16'h8100;
            do_tick();
        end
        fir_coef = {8'h7F, {7{8'h80}}};
        for (int t = 0; t < 9; t++) begin
            echo_in_l = 16'h8000; echo_in_r = 16'h7FFF;
            do_tick();
        end

        // R11: idle holds outputs
        begin
            logic [15:0] ml;
            ml = mix_out_l;
            repeat (4) @(negedge clk);
            check("R11 hold", int'(mix_out_l), int'(ml));
            check("R11 idle valid", int'(out_valid), 0);
        end

        // R9 R10: random with write-disable toggling and right channel quiet
        for (int t = 0; t < 400; t++) begin
            fir_coef   = {$urandom, $urandom};
            echo_vol_l = 8'($urandom); echo_vol_r = 8'($urandom);
            fb_vol     = 8'($urandom);
            echo_in_l  = 16'($urandom);
            echo_in_r  = (t < 100) ? 16'd0 : 16'($urandom);
            main_in_l  = 16'($urandom); main_in_r = 16'($urandom);
            eon_in_l   = 16'($urandom); eon_in_r  = 16'($urandom);
            echo_wr_dis = ($urandom % 3) == 0;
            do_tick();
            if ($urandom % 4 == 0) repeat ($urandom % 3 + 1) @(negedge clk);
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule